// File: doc/BRIEF.md
# Write-Only Two-Wire Clock Configuration Receiver

This block is the configuration front end of a clock generator. It listens on a two-wire serial bus (SMBus/I2C style). When the bus master sends the block's fixed 7-bit address with a write request, the block acknowledges. It then takes the data bytes that follow, in order, into a small bank of configuration registers. The registers drive the clock-generator fields, all of which are outputs of this block:

- the fast/slow rate choice for the two peripheral clock outputs;
- a two-bit output-mode code;
- one run-enable bit for each output group.

Both bus lines are sampled by a system clock that is much faster than the bus clock. A start or a stop is recognised as a change on the data line while the bus clock is high. The acknowledge is produced by pulling the data line low. Every transfer writes from register slot 0 upward, one slot per byte. Slots that hold no field, and any bytes past the last slot, are acknowledged and then dropped. Reads are not supported.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset, `sdaPullDown` is 0. `rateSel` is 2'b11 (both peripheral clocks fast), `modeSel` is 2'b00, and every enable output is all ones.
- R2: A first byte of 0xD2 (address 7'b1101001, last bit 0 = write) is acknowledged. `sdaPullDown` is 1 throughout the ninth bus clock's high phase and is released after that clock's falling edge.
- R3: A first byte whose upper seven bits differ from 7'b1101001, or whose last bit is 1 (read), is not acknowledged. Later bytes of that transfer get no acknowledge and change no register.
- R4: Data bytes arrive most significant bit first. The first data byte goes to slot 0 and each further byte to the next slot. Each data byte of an accepted transfer is acknowledged.
- R5: Slot 0: bit 3 drives `rateSel[1]` and bit 2 drives `rateSel[0]` (1 = fast). Bits 1:0 drive `modeSel`. Bits 7:4 are ignored.
- R6: Slot 1: bits 3:0 drive `cpuEn[3:0]` and bits 7:6 drive `perEn[1:0]`; bits 5:4 are ignored. Slot 2: bits 5:0 drive `pciEn[5:0]` and bit 6 drives `pciFreeEn`; bit 7 is ignored.
- R7: Slot 3: bits 7:0 drive `memEn[7:0]`. Slot 5: bit 4 drives `apicEn` and bits 1:0 drive `refEn[1:0]`; the other bits are ignored.
- R8: Bytes written to slots 4 and 6, and any byte after slot 6, are acknowledged but change no output.
- R9: A stop ends the transfer. A repeated start begins a new address phase. In both cases the next accepted transfer writes from slot 0 again.
- R10: Only a data-line change while the bus clock is high counts as a start or stop. Data-line changes while the bus clock is low are data and never end or restart a transfer.
- R11: A byte cut off by a stop before its eighth bit writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaPullDown | output | 1 | 1 = pull the data line low (acknowledge) |
| rateSel | output | 2 | Peripheral clock rate choice, 1 = fast |
| modeSel | output | 2 | Output mode code |
| cpuEn | output | 4 | Processor clock run enables |
| perEn | output | 2 | Peripheral clock run enables |
| pciEn | output | 6 | Stoppable bus clock run enables |
| pciFreeEn | output | 1 | Free-running bus clock enable |
| memEn | output | 8 | Memory clock run enables |
| apicEn | output | 1 | Interrupt-controller clock enable |
| refEn | output | 2 | Reference clock enables |

## Verification
Errors in the bit counter or the state register show up first on `sdaPullDown`. An acknowledge that is missing, shifted by one bus clock, or given to a foreign address appears within the same byte time. Errors in the slot pointer or the shift register show up on the field outputs. A byte may land one slot off or a dropped slot may leak into a field; the bench sees this within one byte time after the acknowledge, because it compares every field against its model on every system clock outside the short window where a byte is being written.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  localparam int BYTE_W     = 8;
  localparam int BANK_SLOTS = 7;                       // slots 0..6 carry meaning
  localparam int PTR_W      = $clog2(BANK_SLOTS + 1);
  localparam int CNT_W      = $clog2(BYTE_W + 1);

  localparam int SLOT_RATE = 0;
  localparam int SLOT_CPU  = 1;
  localparam int SLOT_PCI  = 2;
  localparam int SLOT_MEM  = 3;
  localparam int SLOT_AUX  = 5;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ADDR,
    S_DATA,
    S_ACK
  } smbState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftBit;
    logic bitVal;
    logic writeByte;
    logic restart;
  } dpCtrl_t;

endpackage

// File: rtl/smb_cfg_ctrl.sv
module smb_cfg_ctrl
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'b1101001,
  parameter int         SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  logic [BYTE_W-1:0]   rxByte,
  output dpCtrl_t             dpCtrl,
  output logic                sdaPullDown
);

  localparam int LINES = 2;

  logic [LINES-1:0] lineRaw;
  logic [LINES-1:0] lineSync;
  logic             sclS, sdaS, sclPrev, sdaPrev;
  logic             sclRise, sclFall, startDet, stopDet;
  logic             addrHit;
  smbState_e        state;
  logic [CNT_W-1:0] bitCnt;

  assign lineRaw = {sclIn, sdaIn};

  generate
    for (genvar g = 0; g < LINES; g++) begin : gSync
      logic [SYNC_DEPTH-1:0] pipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= {pipe[SYNC_DEPTH-2:0], lineRaw[g]};
      end
      assign lineSync[g] = pipe[SYNC_DEPTH-1];
    end
  endgenerate

  assign sclS = lineSync[1];
  assign sdaS = lineSync[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  always_comb begin
    sclRise  = sclS & ~sclPrev;
    sclFall  = ~sclS & sclPrev;
    startDet = sclS & sclPrev & sdaPrev & ~sdaS;
    stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
    addrHit  = (rxByte[7:1] == DEV_ADDR) && !rxByte[0];
  end

  always_comb begin
    dpCtrl.shiftBit  = sclRise && (state == S_ADDR || state == S_DATA)
                       && (bitCnt < CNT_W'(BYTE_W));
    dpCtrl.bitVal    = sdaS;
    dpCtrl.writeByte = sclFall && (state == S_DATA) && (bitCnt == CNT_W'(BYTE_W));
    dpCtrl.restart   = startDet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      bitCnt      <= '0;
      sdaPullDown <= 1'b0;
    end else if (startDet) begin
      state       <= S_ADDR;
      bitCnt      <= '0;
      sdaPullDown <= 1'b0;
    end else if (stopDet) begin
      state       <= S_IDLE;
      bitCnt      <= '0;
      sdaPullDown <= 1'b0;
    end else begin
      unique case (state)
        S_ADDR, S_DATA: begin
          if (sclRise && bitCnt < CNT_W'(BYTE_W)) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall && bitCnt == CNT_W'(BYTE_W)) begin
            if (state == S_DATA || addrHit) begin
              sdaPullDown <= 1'b1;
              state       <= S_ACK;
            end else begin
              sdaPullDown <= 1'b0;
              state       <= S_IDLE;
            end
          end
        end
        S_ACK: begin
          if (sclFall) begin
            sdaPullDown <= 1'b0;
            bitCnt      <= '0;
            state       <= S_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  // acknowledge begins only on a bus clock falling edge
  assert_ack_rises_on_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullDown) |-> $past(sclFall));

  // acknowledge ends on a falling edge or a bus condition
  assert_ack_release_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullDown) |-> $past(sclFall || startDet || stopDet));

  // an idle receiver never touches the data line
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !sdaPullDown);

  // bit counter stays within one byte
  assert_bitcnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W));

  // every committed data byte is acknowledged
  assert_write_then_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.writeByte |=> sdaPullDown);

  // stop returns to idle
  assert_stop_idles_R9: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == S_IDLE));

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  output logic [BYTE_W-1:0] rxByte,
  output logic [1:0]        rateSel,
  output logic [1:0]        modeSel,
  output logic [3:0]        cpuEn,
  output logic [1:0]        perEn,
  output logic [5:0]        pciEn,
  output logic              pciFreeEn,
  output logic [7:0]        memEn,
  output logic              apicEn,
  output logic [1:0]        refEn
);

  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(BANK_SLOTS);

  logic [PTR_W-1:0] slotPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      slotPtr <= '0;
    end else begin
      if (dpCtrl.shiftBit) rxByte <= {rxByte[BYTE_W-2:0], dpCtrl.bitVal};
      if (dpCtrl.restart) slotPtr <= '0;
      else if (dpCtrl.writeByte && slotPtr != PTR_END) slotPtr <= slotPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateSel   <= 2'b11;
      modeSel   <= 2'b00;
      cpuEn     <= '1;
      perEn     <= '1;
      pciEn     <= '1;
      pciFreeEn <= 1'b1;
      memEn     <= '1;
      apicEn    <= 1'b1;
      refEn     <= '1;
    end else if (dpCtrl.writeByte) begin
      case (slotPtr)
        PTR_W'(SLOT_RATE): begin
          rateSel <= rxByte[3:2];
          modeSel <= rxByte[1:0];
        end
        PTR_W'(SLOT_CPU): begin
          cpuEn <= rxByte[3:0];
          perEn <= rxByte[7:6];
        end
        PTR_W'(SLOT_PCI): begin
          pciEn     <= rxByte[5:0];
          pciFreeEn <= rxByte[6];
        end
        PTR_W'(SLOT_MEM): memEn <= rxByte;
        PTR_W'(SLOT_AUX): begin
          apicEn <= rxByte[4];
          refEn  <= rxByte[1:0];
        end
        default: ;
      endcase
    end
  end

  logic unmappedSlot;
  assign unmappedSlot = !(slotPtr == PTR_W'(SLOT_RATE) || slotPtr == PTR_W'(SLOT_CPU) ||
                          slotPtr == PTR_W'(SLOT_PCI)  || slotPtr == PTR_W'(SLOT_MEM) ||
                          slotPtr == PTR_W'(SLOT_AUX));

  // writes to empty slots or past the end leave every field untouched
  assert_unmapped_no_effect_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.writeByte && unmappedSlot) |=>
      ($stable(rateSel) && $stable(modeSel) && $stable(cpuEn) && $stable(perEn) &&
       $stable(pciEn) && $stable(pciFreeEn) && $stable(memEn) && $stable(apicEn) &&
       $stable(refEn)));

  // pointer saturates after the last slot
  assert_ptr_saturates_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.writeByte && !dpCtrl.restart && slotPtr == PTR_END) |=> (slotPtr == PTR_END));

  // a start rewinds to slot 0
  assert_restart_rewinds_R9: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.restart |=> (slotPtr == '0));

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'b1101001,
  parameter int         SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaPullDown,
  output logic [1:0] rateSel,
  output logic [1:0] modeSel,
  output logic [3:0] cpuEn,
  output logic [1:0] perEn,
  output logic [5:0] pciEn,
  output logic       pciFreeEn,
  output logic [7:0] memEn,
  output logic       apicEn,
  output logic [1:0] refEn
);

  dpCtrl_t           dpCtrl;
  logic [BYTE_W-1:0] rxByte;

  smb_cfg_ctrl #(.DEV_ADDR(DEV_ADDR), .SYNC_DEPTH(SYNC_DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .dpCtrl(dpCtrl), .sdaPullDown(sdaPullDown)
  );

  smb_cfg_regs regs_i (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .rxByte(rxByte),
    .rateSel(rateSel), .modeSel(modeSel), .cpuEn(cpuEn), .perEn(perEn),
    .pciEn(pciEn), .pciFreeEn(pciFreeEn), .memEn(memEn), .apicEn(apicEn),
    .refEn(refEn)
  );

endmodule

// File: tb/smb_cfg_slave_tb.sv
module smb_cfg_slave_tb_top;

  localparam int H = 20;   // system clocks per bus half period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaLine;
  logic sdaPullDown;
  logic [1:0] rateSel, modeSel, perEn, refEn;
  logic [3:0] cpuEn;
  logic [5:0] pciEn;
  logic [7:0] memEn;
  logic pciFreeEn, apicEn;

  int errors = 0;
  int checks = 0;
  bit cmpEn = 1'b0;
  bit done = 1'b0;

  // reference model state
  logic [1:0] mRate = 2'b11, mMode = 2'b00, mPer = 2'b11, mRef = 2'b11;
  logic [3:0] mCpu = 4'hF;
  logic [5:0] mPci = 6'h3F;
  logic [7:0] mMem = 8'hFF;
  logic mPciF = 1'b1, mApic = 1'b1;
  bit mAddrOk = 1'b0;
  int mIdx = 0;

  always #5 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullDown;

  smb_cfg_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaPullDown(sdaPullDown), .rateSel(rateSel), .modeSel(modeSel),
    .cpuEn(cpuEn), .perEn(perEn), .pciEn(pciEn), .pciFreeEn(pciFreeEn),
    .memEn(memEn), .apicEn(apicEn), .refEn(refEn)
  );

  function automatic logic [27:0] dutVec();
    return {rateSel, modeSel, cpuEn, perEn, pciEn, pciFreeEn, memEn, apicEn, refEn};
  endfunction

  function automatic logic [27:0] modelVec();
    return {mRate, mMode, mCpu, mPer, mPci, mPciF, mMem, mApic, mRef};
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison of the whole bank (R4..R8 observed at the ports)
  always @(posedge clk) begin
    #3;
    if (cmpEn && rstN) begin
      checks++;
      if (dutVec() !== modelVec()) begin
        errors++;
        $display("FAIL R4 bank act=%h exp=%h t=%0t", dutVec(), modelVec(), $time);
      end
    end
  end

  task automatic waitC(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic modelApply(int idx, logic [7:0] v);
    case (idx)
      0: begin mRate = v[3:2]; mMode = v[1:0]; end
      1: begin mCpu = v[3:0]; mPer = v[7:6]; end
      2: begin mPci = v[5:0]; mPciF = v[6]; end
      3: mMem = v;
      5: begin mApic = v[4]; mRef = v[1:0]; end
      default: ;
    endcase
  endtask

  task automatic startCond();
    if (!sclM) begin
      sdaM = 1'b1; waitC(H);
      sclM = 1'b1; waitC(H);
    end
    sdaM = 1'b0; waitC(H);
    sclM = 1'b0;
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitC(H);
    sclM = 1'b1; waitC(H);
    sdaM = 1'b1; waitC(H);
  endtask

  task automatic sendBit(logic b);
    sdaM = b; waitC(H);
    sclM = 1'b1; waitC(H / 2);
    chk("R10 line free during data bit", int'(sdaPullDown), 0);
    waitC(H / 2);
    sclM = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] v, bit isData, string tag);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    cmpEn = 1'b0;
    sdaM = 1'b1; waitC(H);
    sclM = 1'b1; waitC(H / 2);
    chk(tag, int'(sdaPullDown), int'(mAddrOk));
    waitC(H / 2);
    sclM = 1'b0;
    if (isData && mAddrOk) begin
      modelApply(mIdx, v);
      mIdx++;
    end
    waitC(8);
    chk({tag, " released"}, int'(sdaPullDown), 0);
    cmpEn = 1'b1;
  endtask

  task automatic addrPhase(logic [7:0] a, string tag);
    startCond();
    mAddrOk = (a[7:1] == 7'b1101001) && !a[0];
    mIdx = 0;
    sendByte(a, 1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    waitC(5);
    rstN = 1'b1;
    waitC(3);
    // R1 reset state
    chk("R1 pulldown", int'(sdaPullDown), 0);
    chk("R1 rateSel", int'(rateSel), 3);
    chk("R1 modeSel", int'(modeSel), 0);
    chk("R1 enables", int'({cpuEn, perEn, pciEn, pciFreeEn, memEn, apicEn, refEn}), 24'hFFFFFF);
    cmpEn = 1'b1;

    // R2 R4 R5 R6 R7 R8: full burst including empty slots and overrun
    addrPhase(8'hD2, "R2 address ack");
    sendByte(8'hF6, 1'b1, "R5 slot0 ack");
    sendByte(8'h35, 1'b1, "R6 slot1 ack");
    sendByte(8'hAA, 1'b1, "R6 slot2 ack");
    sendByte(8'h5C, 1'b1, "R7 slot3 ack");
    sendByte(8'h00, 1'b1, "R8 slot4 ack");
    sendByte(8'hE9, 1'b1, "R7 slot5 ack");
    sendByte(8'h00, 1'b1, "R8 slot6 ack");
    sendByte(8'h00, 1'b1, "R8 overrun ack");
    sendByte(8'h12, 1'b1, "R8 overrun ack2");
    stopCond();
    chk("R5 rateSel field", int'(rateSel), 1);
    chk("R7 memEn field", int'(memEn), 8'h5C);

    // R3 foreign address, then read request
    addrPhase(8'hD0, "R3 foreign addr nack");
    sendByte(8'hFF, 1'b1, "R3 foreign data nack");
    stopCond();
    addrPhase(8'hD3, "R3 read nack");
    sendByte(8'hFF, 1'b1, "R3 read data nack");
    stopCond();

    // R9 repeated start rewinds to slot 0
    addrPhase(8'hD2, "R9 address ack");
    sendByte(8'h0F, 1'b1, "R9 slot0 ack");
    sendByte(8'hFF, 1'b1, "R9 slot1 ack");
    addrPhase(8'hD2, "R9 restart addr ack");
    sendByte(8'h08, 1'b1, "R9 slot0 again ack");
    stopCond();
    chk("R9 rewound slot0", int'({rateSel, modeSel}), 4'b1000);

    // R11 truncated byte then fresh transfer
    addrPhase(8'hD2, "R11 address ack");
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b1);
    stopCond();
    chk("R11 truncated byte", int'({rateSel, modeSel}), 4'b1000);
    addrPhase(8'hD2, "R11 next addr ack");
    sendByte(8'h04, 1'b1, "R11 slot0 ack");
    stopCond();
    chk("R11 slot0 after stop", int'({rateSel, modeSel}), 4'b0100);

    // R10 data-line wiggle with bus clock low while idle
    sclM = 1'b0; waitC(H);
    for (int k = 0; k < 4; k++) begin
      sdaM = ~sdaM; waitC(H / 2);
    end
    sdaM = 1'b1; waitC(H);
    sclM = 1'b1; waitC(H);
    chk("R10 no ack after wiggle", int'(sdaPullDown), 0);
    addrPhase(8'hD2, "R10 address after wiggle");
    sendByte(8'h55, 1'b1, "R10 slot0 ack");
    stopCond();
    chk("R10 slot0 value", int'({rateSel, modeSel}), 4'b0101);

    waitC(10);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule